// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block puts a processor core into a low-power standby state and decides how it comes back. When the core issues its wait-for-event strobe, the controller enters one of two sleep modes. In the light mode the clock keeps running. In the deep mode the oscillator is switched off. While the core sleeps, the controller watches the level of the highest pending maskable request, the mask level field and a non-maskable request.

A wake-up ends with a single-cycle wake pulse and exactly one of two outcome pulses:

- **Service:** enter the interrupt handler.
- **Resume:** continue with the instruction after the wait strobe, leaving the request pending.

Leaving deep sleep first turns the oscillator back on and waits a programmable warm-up count. After any external reset, the core is held in reset for a fixed settling interval that covers oscillator start-up.

All pins are plain control and status levels or pulses. Nothing here carries streamed data, so there is no valid/ready handshake and no back-pressure.

Top module: `standby_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `sleep`=0, `osc_en`=1, `core_rst_n`=0, and `wake`, `take_irq` and `resume_next` are 0.
- R2: After `rst_n` rises, `core_rst_n` stays low for exactly `RST_HOLD` clock edges and then stays high. A `wait_stb` seen while `core_rst_n` is low is ignored (`sleep` stays 0).
- R3: A `wait_stb` with `mode_stop`=0 and no request pending gives `sleep`=1 with `osc_en`=1 from the next cycle (light sleep).
- R4: In light sleep, a nonzero `req_lvl` gives a `wake` pulse in the cycle after it is sampled, and `sleep` returns to 0 one cycle later.
- R5: The mask level is `mask_reg[3:0]`; bits [7:4] are ignored. A nonzero `req_lvl` that is greater than or equal to the mask level wakes the core with `take_irq`=1. A mask level of 0 lets any nonzero request be serviced.
- R6: A nonzero `req_lvl` below the mask level wakes the core with `resume_next`=1 and `take_irq`=0.
- R7: `nmi`=1 while asleep wakes the core with `take_irq`=1 whatever the mask level, even with `req_lvl`=0.
- R8: A `wait_stb` with `mode_stop`=1 and no request pending gives `sleep`=1 and `osc_en`=0 from the next cycle (deep sleep).
- R9: In deep sleep, a wake condition raises `osc_en` in the next cycle with `sleep` still 1. After `warm_cnt`+1 further cycles, the `wake` pulse appears.
- R10: `wake`, `take_irq` and `resume_next` each last one cycle. Every `wake` carries exactly one of `take_irq` or `resume_next`, and neither appears without `wake`.
- R11: A `wait_stb` that arrives while a wake condition already holds does not enter sleep. The `wake` pulse with its outcome appears in the next cycle.
- R12: With `req_lvl`=0 and `nmi`=0, sleep continues and no `wake` is produced.
- R13: Asserting `rst_n` low during sleep returns the block at once to its R1 state, and the R2 hold interval restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| mode_stop | input | 1 | Sleep mode select at the wait strobe: 1 deep, 0 light |
| wait_stb | input | 1 | Single-cycle wait-for-event strobe from the core |
| req_lvl | input | LVL_W | Level of the highest pending maskable request, 0 = none |
| mask_reg | input | MASK_W | Mask register; the level field occupies bits [LVL_W-1:0] |
| nmi | input | 1 | Non-maskable request |
| warm_cnt | input | WARM_W | Oscillator warm-up length for deep-sleep exit |
| sleep | output | 1 | Core is in standby |
| osc_en | output | 1 | Oscillator enable |
| core_rst_n | output | 1 | Active-low reset to the core, held through the settling interval |
| wake | output | 1 | Single-cycle wake-up pulse |
| take_irq | output | 1 | With wake: take the interrupt |
| resume_next | output | 1 | With wake: continue after the wait strobe, request left pending |

## Verification
The assertions assume that `rst_n` is the only asynchronous input. They also assume that `wait_stb` is only sampled as meaningful from the light-run state, so a strobe during sleep has no defined effect. The bench drives every input on the falling clock edge and pulses `wait_stb` only while the core is awake. It clears `req_lvl` and `nmi` once a wake has been taken, so each scenario starts from a quiet run state.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_IDLE = 3'd1,
    ST_STOP = 3'd2,
    ST_WARM = 3'd3,
    ST_WAKE = 3'd4
  } sw_state_e;

  typedef struct packed {
    logic hit;   // some wake condition is present
    logic take;  // the wake must enter the handler
  } sw_dec_t;
endpackage

// File: rtl/sw_arbiter.sv
module sw_arbiter
  import sw_pkg::*;
#(
  parameter int LVL_W  = 4,
  parameter int MASK_W = 8
) (
  input  logic [LVL_W-1:0]  req_lvl,
  input  logic [MASK_W-1:0] mask_reg,
  input  logic              nmi,
  output sw_dec_t           dec
);
  logic [LVL_W-1:0] mask_lvl;
  logic             any_req;
  logic             above;

  assign mask_lvl = mask_reg[LVL_W-1:0];
  assign any_req  = |req_lvl;
  assign above    = any_req && (req_lvl >= mask_lvl);

  always_comb begin
    dec.hit  = nmi | any_req;
    dec.take = nmi | above;
  end
endmodule

// File: rtl/sw_downcnt.sv
module sw_downcnt #(
  parameter int W    = 8,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic         zero
);
  localparam logic [W-1:0] INIT_V = W'(INIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= INIT_V;
    else if (load)             cnt <= ld_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/standby_wake_ctrl.sv
module standby_wake_ctrl
  import sw_pkg::*;
#(
  parameter int LVL_W    = 4,
  parameter int MASK_W   = 8,
  parameter int WARM_W   = 8,
  parameter int RST_HOLD = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_stop,
  input  logic              wait_stb,
  input  logic [LVL_W-1:0]  req_lvl,
  input  logic [MASK_W-1:0] mask_reg,
  input  logic              nmi,
  input  logic [WARM_W-1:0] warm_cnt,
  output logic              sleep,
  output logic              osc_en,
  output logic              core_rst_n,
  output logic              wake,
  output logic              take_irq,
  output logic              resume_next
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  sw_state_e state, state_n;
  logic      take_q, take_n;
  sw_dec_t   dec;
  logic      warm_load, warm_dec, warm_zero;
  logic      hold_done;

  sw_arbiter #(.LVL_W(LVL_W), .MASK_W(MASK_W)) u_arb (
    .req_lvl (req_lvl),
    .mask_reg(mask_reg),
    .nmi     (nmi),
    .dec     (dec)
  );

  sw_downcnt #(.W(HOLD_W), .INIT(RST_HOLD)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (1'b0),
    .ld_val({HOLD_W{1'b0}}),
    .dec   (1'b1),
    .zero  (hold_done)
  );

  sw_downcnt #(.W(WARM_W), .INIT(0)) u_warm (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (warm_load),
    .ld_val(warm_cnt),
    .dec   (warm_dec),
    .zero  (warm_zero)
  );

  always_comb begin
    state_n   = state;
    take_n    = take_q;
    warm_load = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (hold_done && wait_stb) begin
          if (dec.hit) begin
            state_n = ST_WAKE;
            take_n  = dec.take;
          end else if (mode_stop) begin
            state_n = ST_STOP;
          end else begin
            state_n = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (dec.hit) begin
          state_n = ST_WAKE;
          take_n  = dec.take;
        end
      end
      ST_STOP: begin
        if (dec.hit) begin
          state_n   = ST_WARM;
          take_n    = dec.take;
          warm_load = 1'b1;
        end
      end
      ST_WARM: begin
        if (warm_zero) state_n = ST_WAKE;
      end
      ST_WAKE: state_n = ST_RUN;
      default: state_n = ST_RUN;
    endcase
  end

  assign warm_dec = (state == ST_WARM) && !warm_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RUN;
      take_q <= 1'b0;
    end else begin
      state  <= state_n;
      take_q <= take_n;
    end
  end

  assign sleep       = (state == ST_IDLE) || (state == ST_STOP) || (state == ST_WARM);
  assign osc_en      = (state != ST_STOP);
  assign core_rst_n  = rst_n && hold_done;
  assign wake        = (state == ST_WAKE);
  assign take_irq    = wake && take_q;
  assign resume_next = wake && !take_q;
endmodule

// File: rtl/standby_wake_ctrl_chk.sv
module standby_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic osc_en,
  input logic core_rst_n,
  input logic wake,
  input logic take_irq,
  input logic resume_next
);
  assert_onehot_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (take_irq ^ resume_next));

  assert_outcome_needs_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq || resume_next) |-> wake);

  assert_wake_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  assert_osc_off_asleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> sleep);

  assert_stop_no_direct_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !wake);

  assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (!sleep && !wake));

  assert_hold_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |=> core_rst_n);

  assert_awake_not_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !sleep);
endmodule

bind standby_wake_ctrl standby_wake_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sleep      (sleep),
  .osc_en     (osc_en),
  .core_rst_n (core_rst_n),
  .wake       (wake),
  .take_irq   (take_irq),
  .resume_next(resume_next)
);

// File: tb/sim_standby_wake_ctrl.sv
`timescale 1ns/1ps
module sim_standby_wake_ctrl;
  localparam int HOLD = 16;
  localparam int WARM = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_stop = 1'b0;
  logic       wait_stb = 1'b0;
  logic [3:0] req_lvl = '0;
  logic [7:0] mask_reg = '0;
  logic       nmi = 1'b0;
  logic [7:0] warm_cnt = 8'(WARM);
  logic       sleep, osc_en, core_rst_n, wake, take_irq, resume_next;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #2.5 clk = ~clk;

  standby_wake_ctrl #(.LVL_W(4), .MASK_W(8), .WARM_W(8), .RST_HOLD(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_stop(mode_stop), .wait_stb(wait_stb),
    .req_lvl(req_lvl), .mask_reg(mask_reg), .nmi(nmi), .warm_cnt(warm_cnt),
    .sleep(sleep), .osc_en(osc_en), .core_rst_n(core_rst_n), .wake(wake),
    .take_irq(take_irq), .resume_next(resume_next)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_outs(input string tag, input logic s, input logic o,
                          input logic w, input logic t, input logic r);
    chk({tag, " sleep"}, sleep, s);
    chk({tag, " osc_en"}, osc_en, o);
    chk({tag, " wake"}, wake, w);
    chk({tag, " take_irq"}, take_irq, t);
    chk({tag, " resume_next"}, resume_next, r);
  endtask

  // R1, R2
  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    chk_outs("R1", 0, 1, 0, 0, 0);
    chk("R1 core_rst_n", core_rst_n, 0);
    rst_n = 1'b1;
    for (int i = 1; i < HOLD; i++) begin
      wait_stb = (i < 5);
      step();
      chk("R2 core held", core_rst_n, 0);
      chk("R2 wait ignored", sleep, 0);
    end
    wait_stb = 1'b0;
    step();
    chk("R2 core released", core_rst_n, 1);
    step();
    chk("R2 still idle run", sleep, 0);
  endtask

  task automatic enter(input logic stop);
    mode_stop = stop;
    wait_stb  = 1'b1;
    step();
    wait_stb  = 1'b0;
  endtask

  // R3, R4, R5
  task automatic t_idle_service();
    enter(0);
    chk_outs("R3 light sleep", 1, 1, 0, 0, 0);
    mask_reg = 8'hA3;
    req_lvl  = 4'd5;
    step();
    chk_outs("R5 service", 0, 1, 1, 1, 0);
    req_lvl = '0;
    step();
    chk_outs("R4 back to run", 0, 1, 0, 0, 0);
  endtask

  // R6
  task automatic t_idle_silent();
    enter(0);
    mask_reg = 8'h59;
    req_lvl  = 4'd4;
    step();
    chk_outs("R6 resume", 0, 1, 1, 0, 1);
    req_lvl = '0;
    step();
    chk_outs("R6 after", 0, 1, 0, 0, 0);
  endtask

  // R5 mask level zero, upper bits ignored
  task automatic t_mask_zero();
    enter(0);
    mask_reg = 8'h70;
    req_lvl  = 4'd1;
    step();
    chk_outs("R5 mask zero", 0, 1, 1, 1, 0);
    req_lvl = '0;
    step();
  endtask

  // R5 equal level
  task automatic t_equal();
    enter(0);
    mask_reg = 8'h07;
    req_lvl  = 4'd7;
    step();
    chk_outs("R5 equal level", 0, 1, 1, 1, 0);
    req_lvl = '0;
    step();
  endtask

  // R7
  task automatic t_nmi();
    enter(0);
    mask_reg = 8'h0F;
    nmi = 1'b1;
    step();
    chk_outs("R7 nmi", 0, 1, 1, 1, 0);
    nmi = 1'b0;
    step();
  endtask

  // R12
  task automatic t_quiet();
    enter(0);
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R12 stays asleep", sleep, 1);
      chk("R12 no wake", wake, 0);
    end
    req_lvl = 4'd2; mask_reg = 8'h00;
    step();
    req_lvl = '0;
    step();
  endtask

  // R8, R9, R10
  task automatic t_stop();
    enter(1);
    chk_outs("R8 deep sleep", 1, 0, 0, 0, 0);
    step();
    chk_outs("R8 stays deep", 1, 0, 0, 0, 0);
    mask_reg = 8'h0C;
    req_lvl  = 4'd3;
    step();
    chk_outs("R9 warm start", 1, 1, 0, 0, 0);
    req_lvl = '0;
    for (int i = 0; i < WARM; i++) begin
      step();
      chk_outs("R9 warming", 1, 1, 0, 0, 0);
    end
    step();
    chk_outs("R9 wake resume", 0, 1, 1, 0, 1);
    step();
    chk_outs("R10 single pulse", 0, 1, 0, 0, 0);
  endtask

  // R11
  task automatic t_wait_pending();
    mask_reg = 8'h02;
    req_lvl  = 4'd6;
    enter(1);
    chk_outs("R11 immediate wake", 0, 1, 1, 1, 0);
    req_lvl = '0;
    step();
    chk_outs("R11 no sleep", 0, 1, 0, 0, 0);
  endtask

  // R13
  task automatic t_reset_asleep();
    enter(1);
    chk("R13 pre asleep", sleep, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk_outs("R13 reset", 0, 1, 0, 0, 0);
    chk("R13 core_rst_n", core_rst_n, 0);
    step();
    rst_n = 1'b1;
    for (int i = 1; i < HOLD; i++) begin
      step();
      chk("R13 hold restart", core_rst_n, 0);
    end
    step();
    chk("R13 released", core_rst_n, 1);
  endtask

  initial begin
    step();
    t_reset();
    t_idle_service();
    t_idle_silent();
    t_mask_zero();
    t_equal();
    t_nmi();
    t_quiet();
    t_stop();
    t_wait_pending();
    t_reset_asleep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule